// File: doc/BRIEF.md
# Mode-Selectable Energy Accumulator

This block integrates a signed per-sample power value into a 42-bit internal energy accumulator, one addition per sample strobe. Before it is added, each sample passes through a selectable conditioning mode: signed, magnitude, positive-only or negative-only. An integration window is counted either in sample strobes or in voltage zero-crossing pulses (half line cycles). The window length is N+1, where N is a programmed 13-bit count.

When a window closes, the internal value moves into a 45-bit signed user energy register, and the internal accumulator clears. The user register either takes the new value, discarding its old content, or adds the new value to what it holds. A ready flag marks each transfer and stays set until the host clears it. Two sticky overflow flags report two's-complement wrap, one in the internal register and one in the user register. The user register is read as two 32-bit words: the upper word carries the integer part, and the low 13 bits of the lower word carry the fraction bits.

Top module: `energy_accum`

## Requirements
- R1: After reset, both energy words read zero and the ready and overflow flags are low.
- R2: Signed mode (mode 0) adds each strobed sample unchanged. A cycle without a strobe adds nothing.
- R3: Absolute mode (mode 1) adds the magnitude of each strobed sample.
- R4: Positive-only mode (mode 2) adds positive samples and treats negative samples as zero.
- R5: Negative-only mode (mode 3) adds negative samples and treats positive samples as zero.
- R6: With the window source at 0, a transfer occurs on the (N+1)th sample strobe. That strobe's own sample is included in the transferred value.
- R7: With the window source at 1, a transfer occurs on the (N+1)th zero-crossing pulse. Sample strobes do not advance the window count, and a sample strobed in the pulse's own cycle is included.
- R8: With the load select at 0, a transfer overwrites the user register with the internal value, sign-extended. The internal accumulator then restarts from zero.
- R9: With the load select at 1, a transfer adds the internal value to the user register. Between transfers the user register does not change.
- R10: Ready goes high on the cycle after a transfer. It stays high until a ready-clear pulse arrives in a cycle with no transfer, and a transfer in the same cycle as the clear wins.
- R11: The high word equals user bits 44:13. The low word holds user bits 12:0 in its bits 12:0, and its bits 31:13 read zero.
- R12: Both registers wrap in two's complement on overflow. Each wrap sets its own sticky overflow flag, which an overflow-clear pulse resets unless a new wrap occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe |
| pwr_i | input | 32 | Signed power sample |
| zc_i | input | 1 | Voltage zero-crossing pulse |
| mode_i | input | 2 | Accumulation mode: 0 signed, 1 absolute, 2 positive-only, 3 negative-only |
| win_src_i | input | 1 | Window unit: 0 samples, 1 half line cycles |
| win_len_i | input | 13 | Window count N; the window is N+1 events |
| ld_add_i | input | 1 | 1 adds to the user register, 0 overwrites it |
| rdy_clr_i | input | 1 | Clear pulse for the ready flag |
| ovf_clr_i | input | 1 | Clear pulse for both overflow flags |
| egy_hi_o | output | 32 | User energy, upper word |
| egy_lo_o | output | 32 | User energy, lower word (fraction bits) |
| rdy_o | output | 1 | Transfer ready flag |
| int_ovf_o | output | 1 | Sticky overflow flag of the internal accumulator |
| usr_ovf_o | output | 1 | Sticky overflow flag of the user register |

## Verification
The assertions check several properties on every cycle. Ready must follow each transfer and hold until cleared. The user words must stay frozen between transfers, and the internal overflow flag must stay sticky. The conditioned contribution must obey the sign rules of positive-only and negative-only modes, must be zero whenever no strobe arrives, and must never close a sample-counted window. Three things cannot be expressed as a local property and are shown only by the bench's sweeps against an arithmetic model: the exact transferred sums, the N+1 window length in both counting units, and wrap-around with its flags.

// File: rtl/energy_accum_pkg.sv
package energy_accum_pkg;
  typedef enum logic [1:0] {
    ACC_SIGNED = 2'd0,
    ACC_ABS    = 2'd1,
    ACC_POS    = 2'd2,
    ACC_NEG    = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/ea_sample_cond.sv
module ea_sample_cond
  import energy_accum_pkg::*;
#(
  parameter int PWR_W = 32,
  parameter int ACC_W = 42
) (
  input  logic                    vld_i,
  input  logic signed [PWR_W-1:0] pwr_i,
  input  acc_mode_e               mode_i,
  output logic signed [ACC_W-1:0] contrib_o
);
  localparam int EXT_W = ACC_W - PWR_W;

  logic signed [ACC_W-1:0] ext;
  logic                    neg;

  assign ext = {{EXT_W{pwr_i[PWR_W-1]}}, pwr_i};
  assign neg = pwr_i[PWR_W-1];

  always_comb begin
    contrib_o = '0;
    if (vld_i) begin
      unique case (mode_i)
        ACC_SIGNED: contrib_o = ext;
        ACC_ABS:    contrib_o = neg ? -ext : ext;
        ACC_POS:    contrib_o = neg ? '0 : ext;
        ACC_NEG:    contrib_o = neg ? ext : '0;
        default:    contrib_o = ext;
      endcase
    end
  end
endmodule

// File: rtl/ea_window_ctr.sv
module ea_window_ctr #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic             zc_i,
  input  logic             src_i,
  input  logic [CNT_W-1:0] win_len_i,
  output logic             xfer_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             evt;

  assign evt    = src_i ? zc_i : smp_vld_i;
  // >= keeps a shortened window from running to counter wrap
  assign xfer_o = evt && (cnt_q >= win_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (xfer_o) cnt_q <= '0;
    else if (evt)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ea_int_acc.sv
module ea_int_acc #(
  parameter int ACC_W = 42
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ACC_W-1:0] contrib_i,
  input  logic                    xfer_i,
  input  logic                    ovf_clr_i,
  output logic signed [ACC_W-1:0] sum_o,
  output logic                    ovf_o
);
  logic signed [ACC_W-1:0] acc_q;
  logic                    wrap;

  assign sum_o = acc_q + contrib_i;
  assign wrap  = (acc_q[ACC_W-1] == contrib_i[ACC_W-1]) &&
                 (sum_o[ACC_W-1] != acc_q[ACC_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      acc_q <= xfer_i ? '0 : sum_o;
      ovf_o <= (ovf_o && !ovf_clr_i) || wrap;
    end
  end
endmodule

// File: rtl/ea_user_reg.sv
module ea_user_reg #(
  parameter int ACC_W = 42,
  parameter int USR_W = 45
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    xfer_i,
  input  logic                    ld_add_i,
  input  logic signed [ACC_W-1:0] sum_i,
  input  logic                    ovf_clr_i,
  output logic signed [USR_W-1:0] usr_o,
  output logic                    ovf_o
);
  localparam int EXT_W = USR_W - ACC_W;

  logic signed [USR_W-1:0] ext;
  logic signed [USR_W-1:0] added;
  logic                    wrap;

  assign ext   = {{EXT_W{sum_i[ACC_W-1]}}, sum_i};
  assign added = usr_o + ext;
  assign wrap  = xfer_i && ld_add_i &&
                 (usr_o[USR_W-1] == ext[USR_W-1]) &&
                 (added[USR_W-1] != usr_o[USR_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usr_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (xfer_i) usr_o <= ld_add_i ? added : ext;
      ovf_o <= (ovf_o && !ovf_clr_i) || wrap;
    end
  end
endmodule

// File: rtl/energy_accum.sv
module energy_accum
  import energy_accum_pkg::*;
#(
  parameter int PWR_W  = 32,
  parameter int ACC_W  = 42,
  parameter int USR_W  = 45,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [PWR_W-1:0]  pwr_i,
  input  logic              zc_i,
  input  logic [1:0]        mode_i,
  input  logic              win_src_i,
  input  logic [CNT_W-1:0]  win_len_i,
  input  logic              ld_add_i,
  input  logic              rdy_clr_i,
  input  logic              ovf_clr_i,
  output logic [WORD_W-1:0] egy_hi_o,
  output logic [WORD_W-1:0] egy_lo_o,
  output logic              rdy_o,
  output logic              int_ovf_o,
  output logic              usr_ovf_o
);
  localparam int FRAC_W = USR_W - WORD_W;
  localparam int PAD_W  = WORD_W - FRAC_W;

  logic signed [ACC_W-1:0] contrib;
  logic signed [ACC_W-1:0] sum;
  logic signed [USR_W-1:0] usr;
  logic                    xfer;

  ea_sample_cond #(.PWR_W(PWR_W), .ACC_W(ACC_W)) u_cond (
    .vld_i     (smp_vld_i),
    .pwr_i     ($signed(pwr_i)),
    .mode_i    (acc_mode_e'(mode_i)),
    .contrib_o (contrib)
  );

  ea_window_ctr #(.CNT_W(CNT_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_vld_i (smp_vld_i),
    .zc_i      (zc_i),
    .src_i     (win_src_i),
    .win_len_i (win_len_i),
    .xfer_o    (xfer)
  );

  ea_int_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .contrib_i (contrib),
    .xfer_i    (xfer),
    .ovf_clr_i (ovf_clr_i),
    .sum_o     (sum),
    .ovf_o     (int_ovf_o)
  );

  ea_user_reg #(.ACC_W(ACC_W), .USR_W(USR_W)) u_usr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xfer_i    (xfer),
    .ld_add_i  (ld_add_i),
    .sum_i     (sum),
    .ovf_clr_i (ovf_clr_i),
    .usr_o     (usr),
    .ovf_o     (usr_ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_o <= 1'b0;
    else         rdy_o <= xfer || (rdy_o && !rdy_clr_i);
  end

  assign egy_hi_o = usr[USR_W-1:FRAC_W];
  assign egy_lo_o = {{PAD_W{1'b0}}, usr[FRAC_W-1:0]};
endmodule

// File: rtl/energy_accum_chk.sv
module energy_accum_chk #(
  parameter int ACC_W  = 42,
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_vld_i,
  input logic              win_src_i,
  input logic [1:0]        mode_i,
  input logic              rdy_clr_i,
  input logic              ovf_clr_i,
  input logic              xfer_i,
  input logic [ACC_W-1:0]  contrib_i,
  input logic [WORD_W-1:0] egy_hi_o,
  input logic [WORD_W-1:0] egy_lo_o,
  input logic              rdy_o,
  input logic              int_ovf_o
);
  a_r10_rdy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> rdy_o);
  a_r10_rdy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o && !rdy_clr_i |=> rdy_o);
  a_r9_user_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable({egy_hi_o, egy_lo_o}));
  a_r2_no_strobe_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |-> contrib_i == '0);
  a_r4_pos_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd2 |-> !contrib_i[ACC_W-1]);
  a_r5_neg_nonpos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd3 |-> (contrib_i[ACC_W-1] || contrib_i == '0));
  a_r6_no_strobe_no_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_src_i && !smp_vld_i |-> !xfer_i);
  a_r12_iovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ovf_o && !ovf_clr_i |=> int_ovf_o);
endmodule

bind energy_accum energy_accum_chk #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_vld_i (smp_vld_i),
  .win_src_i (win_src_i),
  .mode_i    (mode_i),
  .rdy_clr_i (rdy_clr_i),
  .ovf_clr_i (ovf_clr_i),
  .xfer_i    (xfer),
  .contrib_i (contrib),
  .egy_hi_o  (egy_hi_o),
  .egy_lo_o  (egy_lo_o),
  .rdy_o     (rdy_o),
  .int_ovf_o (int_ovf_o)
);

// File: tb/energy_accum_tb.sv
module energy_accum_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_vld = 1'b0;
  logic [31:0] pwr = '0;
  logic        zc = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        src = 1'b0;
  logic [12:0] wl = '0;
  logic        ld = 1'b0;
  logic        rclr = 1'b0;
  logic        oclr = 1'b0;
  logic [31:0] hi, lo;
  logic        rdy, iovf, uovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint m_acc, m_usr, m_cnt;
  bit     m_rdy, m_iovf, m_uovf;
  logic [31:0] lfsr = 32'hACE1_2468;
  string  mtag [4] = '{"R2", "R3", "R4", "R5"};

  always #5 clk = ~clk;

  energy_accum u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .smp_vld_i(smp_vld), .pwr_i(pwr), .zc_i(zc),
    .mode_i(mode), .win_src_i(src), .win_len_i(wl), .ld_add_i(ld),
    .rdy_clr_i(rclr), .ovf_clr_i(oclr), .egy_hi_o(hi), .egy_lo_o(lo),
    .rdy_o(rdy), .int_ovf_o(iovf), .usr_ovf_o(uovf)
  );

  function automatic longint wrap(longint v, int w);
    longint m = (longint'(1) <<< w) - 1;
    longint r = v & m;
    if (r[w-1]) r = r - (longint'(1) <<< w);
    return r;
  endfunction

  function automatic bit out_of(longint v, int w);
    return (v >= (longint'(1) <<< (w-1))) || (v < -(longint'(1) <<< (w-1)));
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    smp_vld = 0; zc = 0; rclr = 0; oclr = 0;
    m_acc = 0; m_usr = 0; m_cnt = 0; m_rdy = 0; m_iovf = 0; m_uovf = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic compare(bit xf);
    logic [44:0] u = m_usr[44:0];
    chk($sformatf("%s/%s user", mtag[mode], ld ? "R9" : "R8"),
        {hi, lo}, {u[44:13], 19'b0, u[12:0]});
    chk("R11 low pad", {45'b0, lo[31:13]}, 64'd0);
    chk(xf ? (src ? "R7 window" : "R6 window") : "R10 ready", {63'b0, rdy}, {63'b0, m_rdy});
    chk("R12 internal ovf", {63'b0, iovf}, {63'b0, m_iovf});
    chk("R12 user ovf", {63'b0, uovf}, {63'b0, m_uovf});
  endtask

  task automatic step(bit v, logic [31:0] p, bit z, bit rc, bit oc);
    longint ps, c, wide, nacc, wu;
    bit evt, xf, iw, uw;
    smp_vld = v; pwr = p; zc = z; rclr = rc; oclr = oc;
    @(posedge clk);
    ps = longint'($signed(p));
    case (mode)
      2'd0: c = ps;
      2'd1: c = ps < 0 ? -ps : ps;
      2'd2: c = ps > 0 ? ps : 0;
      default: c = ps < 0 ? ps : 0;
    endcase
    if (!v) c = 0;
    wide = m_acc + c;
    iw = out_of(wide, 42);
    nacc = wrap(wide, 42);
    evt = src ? z : v;
    xf = evt && (m_cnt >= longint'(wl));
    uw = 0;
    if (xf) begin
      if (ld) begin
        wu = m_usr + nacc;
        uw = out_of(wu, 45);
        m_usr = wrap(wu, 45);
      end else m_usr = nacc;
      m_acc = 0; m_cnt = 0;
    end else begin
      m_acc = nacc;
      if (evt) m_cnt++;
    end
    m_rdy  = xf | (m_rdy & !rc);
    m_iovf = (m_iovf & !oc) | iw;
    m_uovf = (m_uovf & !oc) | uw;
    @(negedge clk);
    compare(xf);
  endtask

  function automatic logic [31:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return 32'($signed(lfsr) >>> 8);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens [3] = '{0, 2, 5};
    do_reset();
    // R1: reset state
    chk("R1 words", {hi, lo}, 64'd0);
    chk("R1 flags", {61'b0, rdy, iovf, uovf}, 64'd0);

    // R2..R11 sweep over mode, window unit, load select and window length
    for (int md = 0; md < 4; md++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 2; l++)
          for (int k = 0; k < 3; k++) begin
            mode = 2'(md); src = s[0]; ld = l[0]; wl = 13'(lens[k]);
            do_reset();
            for (int i = 0; i < 40; i++)
              step((i % 5) != 3, next_rand(), (i % 4) == 1, (i % 9) == 8, 1'b0);
          end

    // R10: ready clear in the same cycle as a transfer -> ready stays set
    mode = 2'd0; src = 1'b0; ld = 1'b0; wl = 13'd0;
    do_reset();
    step(1'b1, 32'd100, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'd7, 1'b0, 1'b1, 1'b0);
    chk("R10 set wins over clear", {63'b0, rdy}, 64'd1);
    step(1'b0, 32'd0, 1'b0, 1'b1, 1'b0);
    chk("R10 cleared", {63'b0, rdy}, 64'd0);

    // R12: internal wrap with a long window
    mode = 2'd0; src = 1'b0; ld = 1'b1; wl = 13'd8191;
    do_reset();
    for (int i = 0; i < 1100; i++) step(1'b1, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R12 internal wrap flag", {63'b0, iovf}, 64'd1);
    step(1'b0, 32'd0, 1'b0, 1'b0, 1'b1);
    chk("R12 internal flag cleared", {63'b0, iovf}, 64'd0);

    // R12: user register wrap in add mode
    wl = 13'd1000;
    do_reset();
    for (int i = 0; i < 9500; i++) step(1'b1, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R12 user wrap flag", {63'b0, uovf}, 64'd1);
    chk("R12 internal no wrap", {63'b0, iovf}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule